// File: doc/BRIEF.md
# NAND flash bus cycle sequencer

This block turns one host request into one complete bus cycle on an 8-bit parallel NAND flash interface. A request carries a cycle kind: command latch, address latch, data write or data read. It also carries a data byte and a memory-space select. The block drives active-low chip enable, write strobe and read strobe, the command and address latch strobes, and the pad controls of the shared data bus (output byte, output enable, input byte). It watches an active-low busy/wait line from the flash.

Each cycle runs through three phases: setup, strobe and hold. Every phase length comes from a timing field, and a field value n means n+1 clock cycles. Setup and hold come from one of two field pairs, and the request's space select chooses the pair. Reads must also respect minimum gaps since the command latch and the address latch were last high. Accesses that drive the bus keep it released for a programmable window first. The timing inputs are captured when a request is accepted, so the host may change them while a cycle is running. When the hold phase ends, the block pulses done, and for reads it presents the byte it sampled.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high, both latch strobes are low, the bus is not driven, ready is high and done is low.
- R2: After acceptance, chip enable is low and the strobe stays high for exactly setup+1 cycles (setup 255 gives 256). The strobe is write strobe for kinds 0 (command), 1 (address) and 2 (write), and read strobe for kind 3 (read). Only one strobe is ever low, and only while chip enable is low.
- R3: With the wait input high, the strobe stays low for exactly strobe-field+1 cycles.
- R4: After the strobe rises, chip enable and the latch strobes hold for exactly hold+1 cycles. Chip enable then goes high.
- R5: Space select 0 takes setup/hold from the common pair and 1 from the attribute pair. The pair that is not selected has no effect.
- R6: The command latch is high for every active cycle of kind 0 only. The address latch is high for every active cycle of kind 1 only. Both are never high together.
- R7: For kinds 0, 1 and 2 the bus output enable is low for the first min(hiz+1, cycle length) active cycles and high after that. For kind 3 it is never high, whatever the hi-z field holds.
- R8: The wait input passes through a two-stage synchronizer. While it is low the strobe stays low past its count. If it returns high during the k-th low cycle, after the count has expired, the strobe is low for k+2 cycles.
- R9: A read strobe first goes low no sooner than cle_re+1 cycles after the last cycle with the command latch high. It also waits at least ale_re+1 cycles after the last cycle with the address latch high. Setup is stretched as needed.
- R10: A read returns, on the data output, the bus byte present during the last read-strobe-low cycle. It is valid together with the done pulse.
- R11: Ready falls in the cycle after acceptance and stays low until the hold phase ends. Done is a one-cycle pulse in the first idle cycle, when ready is high again.
- R12: Timing inputs changed during an active cycle do not alter that cycle. They apply from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_space | input | 1 | 0 common, 1 attribute timing pair |
| req_data | input | 8 | Byte driven for kinds 0 to 2 |
| cfg_cle_re | input | 4 | Command-latch to read-strobe gap code |
| cfg_ale_re | input | 4 | Address-latch to read-strobe gap code |
| cfg_hiz | input | 8 | Bus release window code for driving cycles |
| cfg_strobe | input | 8 | Strobe low time code |
| cfg_setup_com | input | 8 | Setup code, common space |
| cfg_hold_com | input | 8 | Hold code, common space |
| cfg_setup_att | input | 8 | Setup code, attribute space |
| cfg_hold_att | input | 8 | Hold code, attribute space |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus output byte |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus input byte |
| nand_wait_n | input | 1 | Flash wait, active low, asynchronous |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte captured by the last read |

## Verification
Phase lengths are counted in the cycles that follow acceptance, so the first setup cycle is the sample after the accepting edge. Each pin is read half a period after every edge, and the bench classifies each sample as setup, strobe or hold from the pins alone. Done and the read byte are due in the first sample with chip enable high, and done must be gone one sample later. A wait release takes effect on the strobe three edges later: two synchronizer stages plus the phase register. Read gaps are measured as differences in the bench's own edge counter.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  parameter int unsigned NSQ_DATA_W = 8;
  parameter int unsigned NSQ_TIME_W = 8;
  parameter int unsigned NSQ_GAP_W  = 4;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WRITE = 2'd2,
    K_READ  = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } bus_phase_e;

  typedef struct packed {
    logic [NSQ_TIME_W-1:0] setup;
    logic [NSQ_TIME_W-1:0] strobe;
    logic [NSQ_TIME_W-1:0] hold;
    logic [NSQ_TIME_W-1:0] hiz;
    logic [NSQ_GAP_W-1:0]  cle_re;
    logic [NSQ_GAP_W-1:0]  ale_re;
  } acc_timing_t;

  // A phase whose code is n is over once its counter has reached n (n+1 cycles).
  function automatic logic count_reached(input logic [NSQ_TIME_W-1:0] cnt,
                                         input logic [NSQ_TIME_W-1:0] code);
    return cnt >= code;
  endfunction

  // gap holds cycles since the latch was last high; read strobe follows one cycle later.
  function automatic logic gap_met(input logic [NSQ_GAP_W:0]   gap,
                                   input logic [NSQ_GAP_W-1:0] code);
    return gap >= {1'b0, code};
  endfunction

  // Cycles elapsed strictly past the release window (code n keeps n+1 cycles free).
  function automatic logic window_over(input logic [NSQ_TIME_W:0]   elapsed,
                                       input logic [NSQ_TIME_W-1:0] code);
    return elapsed > {1'b0, code};
  endfunction

  function automatic logic drives_bus(input cyc_kind_e k);
    return k != K_READ;
  endfunction
endpackage

// File: rtl/nand_wait_sync.sv
module nand_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= async_n;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
    end
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/nand_timing_snap.sv
module nand_timing_snap
  import nand_seq_pkg::*;
#(
  parameter int unsigned TIME_W = NSQ_TIME_W,
  parameter int unsigned GAP_W  = NSQ_GAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              space,
  input  logic [GAP_W-1:0]  cle_re,
  input  logic [GAP_W-1:0]  ale_re,
  input  logic [TIME_W-1:0] hiz,
  input  logic [TIME_W-1:0] strobe,
  input  logic [TIME_W-1:0] setup_com,
  input  logic [TIME_W-1:0] hold_com,
  input  logic [TIME_W-1:0] setup_att,
  input  logic [TIME_W-1:0] hold_att,
  output acc_timing_t       tim_q
);
  acc_timing_t tim_d;

  always_comb begin
    tim_d.setup  = space ? setup_att : setup_com;
    tim_d.hold   = space ? hold_att  : hold_com;
    tim_d.strobe = strobe;
    tim_d.hiz    = hiz;
    tim_d.cle_re = cle_re;
    tim_d.ale_re = ale_re;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    tim_q <= '0;
    else if (load) tim_q <= tim_d;
endmodule

// File: rtl/nand_gap_track.sv
module nand_gap_track #(
  parameter int unsigned GAP_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           latch_hi,
  output logic [GAP_W:0] gap_q
);
  localparam logic [GAP_W:0] GAP_MAX = '1;
  localparam logic [GAP_W:0] GAP_ONE = {{GAP_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                gap_q <= GAP_MAX;
    else if (latch_hi)         gap_q <= GAP_ONE;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + GAP_ONE;
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int unsigned DATA_W = NSQ_DATA_W,
  parameter int unsigned TIME_W = NSQ_TIME_W,
  parameter int unsigned GAP_W  = NSQ_GAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cyc_kind_e         kind_in,
  input  logic [DATA_W-1:0] data_in,
  input  acc_timing_t       tim,
  input  logic              wait_ok,
  input  logic [GAP_W:0]    cle_gap,
  input  logic [GAP_W:0]    ale_gap,
  output bus_phase_e        phase_q,
  output cyc_kind_e         kind_q,
  output logic [DATA_W-1:0] data_q,
  output logic              bus_free,
  output logic              strobe_end,
  output logic              hold_end
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;
  localparam logic [TIME_W:0]   EL_MAX  = '1;

  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W:0]   elapsed_q;
  logic              setup_end;
  logic              read_gap_ok;
  logic              active;
  bus_phase_e        phase_d;

  assign active      = phase_q != PH_IDLE;
  assign read_gap_ok = (kind_q != K_READ) ||
                       (gap_met(cle_gap, tim.cle_re) && gap_met(ale_gap, tim.ale_re));
  assign setup_end   = (phase_q == PH_SETUP)  && count_reached(cnt_q, tim.setup) && read_gap_ok;
  assign strobe_end  = (phase_q == PH_STROBE) && count_reached(cnt_q, tim.strobe) && wait_ok;
  assign hold_end    = (phase_q == PH_HOLD)   && count_reached(cnt_q, tim.hold);
  assign bus_free    = window_over(elapsed_q, tim.hiz);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start)      phase_d = PH_SETUP;
      PH_SETUP:  if (setup_end)  phase_d = PH_STROBE;
      PH_STROBE: if (strobe_end) phase_d = PH_HOLD;
      PH_HOLD:   if (hold_end)   phase_d = PH_IDLE;
      default:                   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind_q    <= K_CMD;
      data_q    <= '0;
      cnt_q     <= '0;
      elapsed_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (start) begin
        kind_q    <= kind_in;
        data_q    <= data_in;
        cnt_q     <= '0;
        elapsed_q <= '0;
      end else begin
        if (phase_d != phase_q)                cnt_q <= '0;
        else if (active && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
        if (active && elapsed_q != EL_MAX)     elapsed_q <= elapsed_q + 1'b1;
      end
    end
endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int unsigned DATA_W = NSQ_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_phase_e        phase,
  input  cyc_kind_e         kind,
  input  logic [DATA_W-1:0] data,
  input  logic              bus_free,
  input  logic              strobe_end,
  input  logic              hold_end,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  logic active;
  logic strobing;

  assign active   = phase != PH_IDLE;
  assign strobing = phase == PH_STROBE;

  assign ce_n  = !active;
  assign cle   = active && (kind == K_CMD);
  assign ale   = active && (kind == K_ADDR);
  assign we_n  = !(strobing && drives_bus(kind));
  assign re_n  = !(strobing && !drives_bus(kind));
  assign dq_o  = data;
  assign dq_oe = active && drives_bus(kind) && bus_free;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= hold_end;
      if (strobe_end && kind == K_READ) rd_data <= dq_i;
    end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = NSQ_DATA_W,
  parameter int unsigned TIME_W      = NSQ_TIME_W,
  parameter int unsigned GAP_W       = NSQ_GAP_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_space,
  input  logic [DATA_W-1:0] req_data,
  input  logic [GAP_W-1:0]  cfg_cle_re,
  input  logic [GAP_W-1:0]  cfg_ale_re,
  input  logic [TIME_W-1:0] cfg_hiz,
  input  logic [TIME_W-1:0] cfg_strobe,
  input  logic [TIME_W-1:0] cfg_setup_com,
  input  logic [TIME_W-1:0] cfg_hold_com,
  input  logic [TIME_W-1:0] cfg_setup_att,
  input  logic [TIME_W-1:0] cfg_hold_att,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_wait_n,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned N_LATCH = 2;

  bus_phase_e        phase;
  cyc_kind_e         kind;
  logic [DATA_W-1:0] data;
  acc_timing_t       tim;
  logic              accept;
  logic              wait_ok;
  logic              bus_free;
  logic              strobe_end;
  logic              hold_end;
  logic [GAP_W:0]    gap [N_LATCH];
  logic [N_LATCH-1:0] latch_hi;

  assign req_ready = phase == PH_IDLE;
  assign accept    = req_valid && req_ready;
  assign latch_hi  = {nand_ale, nand_cle};

  nand_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(nand_wait_n), .sync_n(wait_ok)
  );

  nand_timing_snap #(.TIME_W(TIME_W), .GAP_W(GAP_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(accept), .space(req_space),
    .cle_re(cfg_cle_re), .ale_re(cfg_ale_re), .hiz(cfg_hiz), .strobe(cfg_strobe),
    .setup_com(cfg_setup_com), .hold_com(cfg_hold_com),
    .setup_att(cfg_setup_att), .hold_att(cfg_hold_att), .tim_q(tim)
  );

  for (genvar i = 0; i < N_LATCH; i++) begin : g_gap
    nand_gap_track #(.GAP_W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .latch_hi(latch_hi[i]), .gap_q(gap[i])
    );
  end

  nand_phase_fsm #(.DATA_W(DATA_W), .TIME_W(TIME_W), .GAP_W(GAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .kind_in(cyc_kind_e'(req_kind)),
    .data_in(req_data), .tim(tim), .wait_ok(wait_ok),
    .cle_gap(gap[0]), .ale_gap(gap[1]),
    .phase_q(phase), .kind_q(kind), .data_q(data), .bus_free(bus_free),
    .strobe_end(strobe_end), .hold_end(hold_end)
  );

  nand_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind), .data(data),
    .bus_free(bus_free), .strobe_end(strobe_end), .hold_end(hold_end),
    .dq_i(nand_dq_i), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .done(rsp_done), .rd_data(rsp_data)
  );
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic rsp_done,
  input logic wait_ok,
  input logic strobe_end
);
  // R1: idle pins whenever the sequencer can take a request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe));

  // R2: never both strobes
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nand_we_n || nand_re_n);

  // R2: a strobe only inside chip enable
  p_strobe_in_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R6: latch strobes exclusive
  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R7: no drive while reading
  p_read_undriven_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R8: a waiting flash keeps the strobe low
  p_wait_extend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_ok && (!nand_we_n || !nand_re_n)) |=> (!nand_we_n || !nand_re_n));

  // R10: the capture cycle is the last read-strobe cycle
  p_capture_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_end && !nand_re_n) |=> nand_re_n);

  // R11: done is a single pulse and comes with ready
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  // R11: acceptance makes the block busy
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind nand_cycle_seq nand_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe),
  .rsp_done(rsp_done), .wait_ok(wait_ok), .strobe_end(strobe_end)
);

// File: tb/nand_cycle_seq_bench.sv
`timescale 1ns/1ps
module nand_cycle_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_space;
  logic [1:0] req_kind;
  logic [7:0] req_data;
  logic [3:0] cfg_cle_re, cfg_ale_re;
  logic [7:0] cfg_hiz, cfg_strobe, cfg_setup_com, cfg_hold_com, cfg_setup_att, cfg_hold_att;
  logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_o, nand_dq_i, rsp_data;
  logic       nand_wait_n, rsp_done;

  always #2.5 clk = ~clk;

  nand_cycle_seq u_nand_cycle_seq (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) nand_dq_i <= 8'h40 + cyc[7:0];

  int n_chk = 0, n_fail = 0;
  int r_setup, r_strobe, r_hold, r_undriven, r_latch_err, r_ready_err;
  int r_first_re, last_cle, last_ale, k_release_at;
  logic r_done, r_ready_end, r_done_after, k_cfg_swap;
  logic [7:0] r_rdata, r_last_rd;

  typedef struct packed {
    logic [1:0] kind;
    logic       space;
    logic [7:0] data, sc, hc, sa, ha, st, hz;
    logic [8:0] e_su, e_st, e_ho, e_hz;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 8'hA5, 8'd0, 8'd0, 8'd9, 8'd9, 8'd0, 8'd0, 9'd1, 9'd1, 9'd1, 9'd1},
    '{2'd1, 1'b0, 8'h3C, 8'd2, 8'd1, 8'd9, 8'd9, 8'd3, 8'd1, 9'd3, 9'd4, 9'd2, 9'd2},
    '{2'd2, 1'b0, 8'h5A, 8'd4, 8'd3, 8'd9, 8'd9, 8'd2, 8'd5, 9'd5, 9'd3, 9'd4, 9'd6},
    '{2'd2, 1'b1, 8'hC3, 8'd1, 8'd1, 8'd3, 8'd2, 8'd1, 8'd0, 9'd4, 9'd2, 9'd3, 9'd1},
    '{2'd3, 1'b0, 8'h00, 8'd1, 8'd2, 8'd9, 8'd9, 8'd4, 8'd7, 9'd2, 9'd5, 9'd3, 9'd10},
    '{2'd3, 1'b1, 8'h00, 8'd0, 8'd0, 8'd2, 8'd4, 8'd0, 8'd0, 9'd3, 9'd1, 9'd5, 9'd9},
    '{2'd0, 1'b1, 8'h70, 8'd5, 8'd5, 8'd0, 8'd0, 8'd5, 8'd2, 9'd1, 9'd6, 9'd1, 9'd3},
    '{2'd2, 1'b0, 8'hFF, 8'd0, 8'd0, 8'd9, 8'd9, 8'd0, 8'd2, 9'd1, 9'd1, 9'd1, 9'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_zero();
    cfg_cle_re = '0; cfg_ale_re = '0; cfg_hiz = '0; cfg_strobe = '0;
    cfg_setup_com = '0; cfg_hold_com = '0; cfg_setup_att = '0; cfg_hold_att = '0;
  endtask

  // Issue one request and classify every active cycle from the pins.
  task automatic run_acc(input logic [1:0] kind, input logic space, input logic [7:0] data);
    int guard;
    logic seen;
    @(negedge clk); #1;
    req_kind = kind; req_space = space; req_data = data; req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    r_setup = 0; r_strobe = 0; r_hold = 0; r_undriven = 0;
    r_latch_err = 0; r_ready_err = 0; r_first_re = -1; seen = 1'b0; guard = 0;
    while (nand_ce_n == 1'b0 && guard < 4000) begin
      guard++;
      if (nand_cle) last_cle = cyc;
      if (nand_ale) last_ale = cyc;
      if (nand_cle != (kind == 2'd0) || nand_ale != (kind == 2'd1)) r_latch_err++;
      if (req_ready) r_ready_err++;
      if (!nand_dq_oe) r_undriven++;
      if (!nand_we_n || !nand_re_n) begin
        if (!seen && !nand_re_n) r_first_re = cyc;
        seen = 1'b1;
        r_strobe++;
        if (!nand_re_n) r_last_rd = nand_dq_i;
        if (k_release_at != 0 && r_strobe == k_release_at) nand_wait_n = 1'b1;
      end else if (!seen) r_setup++;
      else r_hold++;
      if (k_cfg_swap && guard == 1) begin
        cfg_setup_com = 8'd30; cfg_hold_com = 8'd30; cfg_strobe = 8'd30;
      end
      @(negedge clk); #1;
    end
    if (guard >= 4000) chk("R11 access never ended", guard, 0);
    r_done = rsp_done; r_ready_end = req_ready; r_rdata = rsp_data;
    @(negedge clk); #1;
    r_done_after = rsp_done;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_space = 1'b0; req_data = '0;
    nand_wait_n = 1'b1; k_release_at = 0; k_cfg_swap = 1'b0;
    last_cle = 0; last_ale = 0;
    cfg_zero();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 1);
    chk("R1 we_n", nand_we_n, 1);
    chk("R1 re_n", nand_re_n, 1);
    chk("R1 latches", {nand_cle, nand_ale}, 0);
    chk("R1 dq_oe", nand_dq_oe, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", rsp_done, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      cfg_setup_com = VEC[i].sc; cfg_hold_com = VEC[i].hc;
      cfg_setup_att = VEC[i].sa; cfg_hold_att = VEC[i].ha;
      cfg_strobe = VEC[i].st; cfg_hiz = VEC[i].hz;
      run_acc(VEC[i].kind, VEC[i].space, VEC[i].data);
      chk(VEC[i].space ? "R5 attr setup" : "R2 setup", r_setup, int'(VEC[i].e_su));
      chk("R3 strobe", r_strobe, int'(VEC[i].e_st));
      chk(VEC[i].space ? "R5 attr hold" : "R4 hold", r_hold, int'(VEC[i].e_ho));
      chk("R7 undriven cycles", r_undriven, int'(VEC[i].e_hz));
      chk("R6 latch strobes", r_latch_err, 0);
      chk("R11 ready low while busy", r_ready_err, 0);
      chk("R11 done with idle", {r_done, r_ready_end}, 3);
      chk("R11 done single pulse", r_done_after, 0);
      if (VEC[i].kind == 2'd3) chk("R10 read byte", r_rdata, r_last_rd);
    end

    // R2 boundary: setup code 255 lasts 256 cycles
    cfg_zero(); cfg_setup_com = 8'd255;
    run_acc(2'd2, 1'b0, 8'h11);
    chk("R2 setup 255", r_setup, 256);
    // R4 and R5 boundary: attribute hold 255, common hold ignored
    cfg_zero(); cfg_hold_att = 8'd255; cfg_hold_com = 8'd7;
    run_acc(2'd1, 1'b1, 8'h22);
    chk("R4 hold 255 attr", r_hold, 256);
    chk("R5 setup attr zero", r_setup, 1);

    // R12: change timings mid-cycle, then see them take effect next time
    cfg_zero(); cfg_setup_com = 8'd1; cfg_hold_com = 8'd1; cfg_strobe = 8'd2;
    k_cfg_swap = 1'b1;
    run_acc(2'd2, 1'b0, 8'h33);
    k_cfg_swap = 1'b0;
    chk("R12 setup unchanged", r_setup, 2);
    chk("R12 strobe unchanged", r_strobe, 3);
    chk("R12 hold unchanged", r_hold, 2);
    run_acc(2'd2, 1'b0, 8'h34);
    chk("R12 next setup", r_setup, 31);

    // R8: wait held low, released during the 6th strobe cycle
    cfg_zero(); cfg_strobe = 8'd1;
    nand_wait_n = 1'b0;
    k_release_at = 6;
    run_acc(2'd2, 1'b0, 8'h44);
    k_release_at = 0;
    chk("R8 strobe stretched", r_strobe, 8);
    chk("R8 hold unaffected", r_hold, 1);
    // R8 with wait low on a read as well
    nand_wait_n = 1'b0;
    k_release_at = 3;
    run_acc(2'd3, 1'b0, 8'h00);
    k_release_at = 0;
    chk("R8 read strobe stretched", r_strobe, 5);
    chk("R10 read byte after wait", r_rdata, r_last_rd);

    // R9: command latch to read strobe gap
    cfg_zero(); cfg_cle_re = 4'd15;
    run_acc(2'd0, 1'b0, 8'h00);
    run_acc(2'd3, 1'b0, 8'h00);
    chk("R9 cle gap", r_first_re - last_cle, 16);
    // R9: address latch to read strobe gap
    cfg_zero(); cfg_ale_re = 4'd9;
    run_acc(2'd1, 1'b0, 8'h05);
    run_acc(2'd3, 1'b0, 8'h00);
    chk("R9 ale gap", r_first_re - last_ale, 10);
    chk("R10 read byte gap", r_rdata, r_last_rd);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule